// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a clocked, single-port static memory. Address, data and control are all sampled on the rising clock edge. It serves three kinds of request: single-word writes, single-word reads, and four-beat read bursts. When a burst starts, the block stores the start address. After that, an internal pointer generates each following address, so the master can drive anything on the address bus while the burst runs.

A read costs one clock to capture the request and one clock to return the word. A single read therefore takes two clocks. A burst returns its first word two clocks after capture and each later word one clock after the one before it. Four words from consecutive locations thus take five clocks, not eight.

The master can pause a running burst between beats by holding the advance input low. The burst then picks up again at the same next address. Releasing chip select ends a burst at once. A new start strobe or a write also ends it.

Top module: `ssram_burst`

## Requirements
- R1: While reset is high and on the first clock after it, `rvalid` is 0 and `rdata` is all zeros.
- R2: A write happens on an edge where `cs_n`=0 and `we`=1. It stores `wdata` at `addr` on that edge, and no read word is returned after it. With `cs_n`=1 the write inputs change no location.
- R3: A single read starts on an edge where the block is idle and `cs_n`=0, `we`=0, `burst_start`=0. After the next edge, `rvalid`=1 and `rdata` holds the captured location; `cs_n` must stay low for that edge. Four back-to-back single reads take eight clocks.
- R4: A burst starts on an edge where `cs_n`=0, `we`=0, `burst_start`=1, and the address is captured on that edge. Without suspends, the four words arrive after the following four edges, from the captured address plus 0, 1, 2 and 3. The whole burst takes five clocks, and `addr` is ignored after capture.
- R5: Burst addresses increment modulo the array depth (2^AW), so a burst that starts near the top of the array wraps to location 0.
- R6: An edge inside a burst after its first beat, with `adv`=0, delivers no word. On that edge `rvalid` goes to 0 and `rdata` keeps its value. The next edge with `adv`=1 returns the next address in sequence.
- R7: After the capture edge of any read, `rvalid` is 0 and `rdata` is unchanged. `adv` has no effect on the first beat.
- R8: An edge with `cs_n`=1 delivers no word, starts no access and aborts any running burst. A later request with `cs_n`=0 and `burst_start`=0 is then taken as a new single read.
- R9: `burst_start` during a running burst abandons it and begins a new burst at the newly captured address, with the same two-clock first-beat latency.
- R10: A write during a running burst takes priority: it stores the data and ends the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| we | input | 1 | Write request |
| burst_start | input | 1 | Starts a four-beat read burst |
| adv | input | 1 | Advance (1) or suspend (0) a running burst |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| rvalid | output | 1 | High for one clock per returned word |

## Verification
Every returned word is due exactly one edge after the edge on which its beat is issued. For a read, that is two edges after capture for the first word. Each later burst word follows one edge after the previous word, plus one edge for each suspend clock.

The bench drives inputs on the falling edge and samples on the next falling edge, which is half a clock after the rising edge that updated the outputs. This lets it count edges exactly. It measures the two-clock single-read cost and the five-clock burst cost by counting edges, not by waiting for `rvalid`. It also checks `rvalid`=0 on capture, suspend and abort edges against a bench-side copy of the array.

// File: rtl/ssram_pkg.sv
`timescale 1ns/1ps
package ssram_pkg;

    // Operation selected on a clock edge, in priority order of decode.
    typedef enum logic [2:0] {
        OP_IDLE,    // nothing selected, nothing running
        OP_ABORT,   // chip deselected while a read is running
        OP_WRITE,   // single-beat store
        OP_START,   // capture a burst start address
        OP_SINGLE,  // capture a single-read address
        OP_STEP,    // deliver one beat
        OP_HOLD     // burst suspended this clock
    } op_e;

    // Sequencer flags carried between clocks.
    typedef struct packed {
        logic busy;   // a read is in progress
        logic first;  // next beat is the first one (latency clock passed)
    } seq_flags_t;

    localparam seq_flags_t SEQ_IDLE = '{busy: 1'b0, first: 1'b0};
    localparam seq_flags_t SEQ_LOAD = '{busy: 1'b1, first: 1'b1};

    function automatic op_e decode_op(
        input logic       cs_n,
        input logic       we,
        input logic       start,
        input logic       adv,
        input seq_flags_t flags
    );
        if (cs_n)
            return flags.busy ? OP_ABORT : OP_IDLE;
        if (we)
            return OP_WRITE;
        if (start)
            return OP_START;
        if (!flags.busy)
            return OP_SINGLE;
        if (flags.first || adv)
            return OP_STEP;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/ssram_store.sv
`timescale 1ns/1ps
module ssram_store #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0][DW-1:0] words;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == AW'(g)))
                word_q <= wr_data;
        end
        assign words[g] = word_q;
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/ssram_seq.sv
`timescale 1ns/1ps
module ssram_seq
    import ssram_pkg::*;
#(
    parameter int AW        = 4,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          we,
    input  logic          burst_start,
    input  logic          adv,
    input  logic [AW-1:0] addr,
    output logic          wr_en,
    output logic [AW-1:0] rd_ptr,
    output logic          beat
);
    localparam int CW = $clog2(BURST_LEN + 1);

    seq_flags_t    flags_q;
    logic [CW-1:0] left_q;
    logic [AW-1:0] ptr_q;
    op_e           op;

    always_comb op = decode_op(cs_n, we, burst_start, adv, flags_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= SEQ_IDLE;
            left_q  <= '0;
            ptr_q   <= '0;
        end else begin
            unique case (op)
                OP_ABORT, OP_WRITE: flags_q <= SEQ_IDLE;
                OP_START: begin
                    flags_q <= SEQ_LOAD;
                    left_q  <= CW'(BURST_LEN);
                    ptr_q   <= addr;
                end
                OP_SINGLE: begin
                    flags_q <= SEQ_LOAD;
                    left_q  <= CW'(1);
                    ptr_q   <= addr;
                end
                OP_STEP: begin
                    ptr_q         <= ptr_q + AW'(1);
                    left_q        <= left_q - CW'(1);
                    flags_q.first <= 1'b0;
                    if (left_q == CW'(1))
                        flags_q.busy <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign wr_en  = (op == OP_WRITE);
    assign beat   = (op == OP_STEP);
    assign rd_ptr = ptr_q;

endmodule

// File: rtl/ssram_out.sv
`timescale 1ns/1ps
module ssram_out #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beat,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= beat;
            if (beat)
                rdata <= word;
        end
    end
endmodule

// File: rtl/ssram_burst.sv
`timescale 1ns/1ps
module ssram_burst #(
    parameter int AW        = 4,
    parameter int DW        = 8,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          we,
    input  logic          burst_start,
    input  logic          adv,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic          wr_en;
    logic          beat;
    logic [AW-1:0] rd_ptr;
    logic [DW-1:0] rd_word;

    ssram_seq #(.AW(AW), .BURST_LEN(BURST_LEN)) u_seq (
        .clk(clk), .rst(rst), .cs_n(cs_n), .we(we),
        .burst_start(burst_start), .adv(adv), .addr(addr),
        .wr_en(wr_en), .rd_ptr(rd_ptr), .beat(beat)
    );

    ssram_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(addr), .wr_data(wdata),
        .rd_addr(rd_ptr), .rd_data(rd_word)
    );

    ssram_out #(.DW(DW)) u_out (
        .clk(clk), .rst(rst), .beat(beat), .word(rd_word),
        .rdata(rdata), .rvalid(rvalid)
    );

endmodule

// File: rtl/ssram_burst_chk.sv
`timescale 1ns/1ps
module ssram_burst_chk #(
    parameter int DW        = 8,
    parameter int BURST_LEN = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          we,
    input logic          burst_start,
    input logic [DW-1:0] rdata,
    input logic          rvalid
);
    localparam int RW = $clog2(BURST_LEN + 1) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (rvalid)
            run_q <= (run_q == RW'(BURST_LEN)) ? run_q : run_q + RW'(1);
        else
            run_q <= '0;
    end

    // R8
    desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !rvalid);

    // R2
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we) |=> !rvalid);

    // R7
    capture_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !we && burst_start) |=> !rvalid);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> $stable(rdata));

    // R3
    beat_source_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $past(!cs_n && !we && !burst_start));

    // R4
    run_length_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (run_q < RW'(BURST_LEN)));

endmodule

bind ssram_burst ssram_burst_chk #(.DW(DW), .BURST_LEN(BURST_LEN)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we(we),
    .burst_start(burst_start), .rdata(rdata), .rvalid(rvalid)
);

// File: tb/ssram_burst_bench.sv
`timescale 1ns/1ps
module ssram_burst_bench;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int BL    = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          cs_n, we, burst_start, adv;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int checks   = 0;
    int failures = 0;
    int edges    = 0;
    bit done     = 1'b0;
    logic [DW-1:0] model [DEPTH];

    always #2 clk = ~clk;
    always @(posedge clk) edges++;

    ssram_burst #(.AW(AW), .DW(DW), .BURST_LEN(BL)) u_ssram_burst (
        .clk(clk), .rst(rst), .cs_n(cs_n), .we(we),
        .burst_start(burst_start), .adv(adv), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [DW-1:0] pattern(input int a);
        return DW'((a * 37 + 5) & 8'hFF);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1'b1; we = 1'b0; burst_start = 1'b0; adv = 1'b1;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cs_n = 1'b0; we = 1'b1; burst_start = 1'b0; addr = a; wdata = d;
        tick();
        chk("R2 no word after write", 32'(rvalid), 0);
        model[a] = d;
        we = 1'b0;
    endtask

    task automatic single(input logic [AW-1:0] a);
        logic [DW-1:0] held;
        cs_n = 1'b0; we = 1'b0; burst_start = 1'b0; addr = a;
        held = rdata;
        tick();
        chk("R7 capture clock rvalid", 32'(rvalid), 0);
        chk("R7 capture clock rdata held", 32'(rdata), 32'(held));
        addr = a ^ AW'(5);
        tick();
        chk("R3 single rvalid", 32'(rvalid), 1);
        chk("R3 single rdata", 32'(rdata), 32'(model[a]));
    endtask

    task automatic burst(input logic [AW-1:0] a, input int susp, output int cyc);
        logic [DW-1:0] held;
        logic [AW-1:0] nxt;
        cyc = 0;
        cs_n = 1'b0; we = 1'b0; burst_start = 1'b1; addr = a; adv = 1'b0;
        tick(); cyc++;
        chk("R7 burst capture rvalid", 32'(rvalid), 0);
        burst_start = 1'b0;
        addr = ~a;
        for (int k = 0; k < BL; k++) begin
            if (k > 0 && k == susp) begin
                adv = 1'b0;
                held = rdata;
                tick(); cyc++;
                chk("R6 suspend rvalid", 32'(rvalid), 0);
                chk("R6 suspend rdata held", 32'(rdata), 32'(held));
            end
            adv = (k == 0) ? 1'b0 : 1'b1;
            addr = addr + AW'(3);
            tick(); cyc++;
            nxt = a + AW'(k);
            chk("R4 burst rvalid", 32'(rvalid), 1);
            chk("R5 burst rdata", 32'(rdata), 32'(model[nxt]));
        end
        adv = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cyc;
        int e0;
        rst = 1'b1; idle(); addr = '0; wdata = '0;
        repeat (3) tick();
        chk("R1 reset rvalid", 32'(rvalid), 0);
        chk("R1 reset rdata", 32'(rdata), 0);
        rst = 1'b0;
        tick();
        chk("R1 first clock after reset rvalid", 32'(rvalid), 0);

        for (int a = 0; a < DEPTH; a++) do_write(AW'(a), pattern(a));
        idle(); tick();

        // R2: write with chip deselected must not change the location
        cs_n = 1'b1; we = 1'b1; addr = AW'(3); wdata = ~model[3];
        tick();
        chk("R8 deselected write rvalid", 32'(rvalid), 0);
        idle(); tick();
        single(AW'(3));
        idle(); tick();

        // R3: every location by single read, first four timed back to back
        e0 = edges;
        for (int a = 0; a < 4; a++) single(AW'(a));
        chk("R3 four singles take eight clocks", 32'(edges - e0), 8);
        for (int a = 4; a < DEPTH; a++) single(AW'(a));
        idle(); tick();

        // R4 R5 R6: a burst from every start address, varied suspend point
        for (int a = 0; a < DEPTH; a++) begin
            burst(AW'(a), a % 5, cyc);
            if (a % 5 == 0 || a % 5 == 4)
                chk("R4 burst takes five clocks", 32'(cyc), 5);
            else
                chk("R6 suspended burst takes six clocks", 32'(cyc), 6);
            idle(); tick();
            chk("R8 idle after burst", 32'(rvalid), 0);
        end

        // R8: deselect aborts a running burst
        cs_n = 1'b0; burst_start = 1'b1; addr = AW'(5);
        tick();
        burst_start = 1'b0;
        tick();
        chk("R4 abort setup first beat", 32'(rdata), 32'(model[5]));
        cs_n = 1'b1;
        tick();
        chk("R8 abort rvalid", 32'(rvalid), 0);
        cs_n = 1'b0; addr = AW'(12);
        tick();
        chk("R8 new single capture", 32'(rvalid), 0);
        tick();
        chk("R8 single after abort rvalid", 32'(rvalid), 1);
        chk("R8 single after abort rdata", 32'(rdata), 32'(model[12]));
        idle(); tick();

        // R8: start strobe with chip deselected starts nothing
        cs_n = 1'b1; burst_start = 1'b1; addr = AW'(2);
        tick();
        chk("R8 deselected start rvalid", 32'(rvalid), 0);
        burst_start = 1'b0;
        tick();
        chk("R8 deselected start no beat", 32'(rvalid), 0);

        // R9: restart during a burst
        cs_n = 1'b0; burst_start = 1'b1; addr = AW'(9);
        tick();
        burst_start = 1'b0;
        tick();
        chk("R9 first burst beat", 32'(rdata), 32'(model[9]));
        burst_start = 1'b1; addr = AW'(14);
        tick();
        chk("R9 restart capture rvalid", 32'(rvalid), 0);
        burst_start = 1'b0; addr = AW'(0);
        for (int k = 0; k < BL; k++) begin
            tick();
            chk("R9 restarted beat rvalid", 32'(rvalid), 1);
            chk("R9 restarted beat rdata", 32'(rdata), 32'(model[AW'(14 + k)]));
        end
        idle(); tick();

        // R10: write during a burst ends it
        cs_n = 1'b0; burst_start = 1'b1; addr = AW'(1);
        tick();
        burst_start = 1'b0;
        tick();
        we = 1'b1; addr = AW'(6); wdata = 8'h3C;
        tick();
        chk("R10 write in burst rvalid", 32'(rvalid), 0);
        model[6] = 8'h3C;
        we = 1'b0;
        tick();
        chk("R10 burst ended, single capture", 32'(rvalid), 0);
        tick();
        chk("R10 read back rvalid", 32'(rvalid), 1);
        chk("R10 read back rdata", 32'(rdata), 32'h3C);
        idle(); tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule